// File: doc/BRIEF.md
# Latched Serial-to-Parallel Sink Driver

This block turns a slow serial bit stream into 32 parallel channel controls. It takes a serial clock, a serial data bit, a latch-open level, an unblank level and a phase level from external pins. It samples all five through synchronizers in a fast system clock domain. Each falling edge of the serial clock pushes one bit into a 32-stage shift chain. The newest bit sits at channel 1, and the oldest of the last 32 bits sits at channel 32. The last stage is also driven onto a serial data output, so several of these blocks can be chained.

A bank of holding registers behaves like a set of transparent latches. The bank follows the shift chain while latch-open is high and keeps its contents while latch-open is low. The output stage combines the bank with the unblank and phase levels and produces one "sink on" bit per channel. A 1 on that bit means the channel's driver is sinking current. With unblank low, the phase level forces every channel on or every channel off. With unblank high, the phase level selects whether each channel follows its latch bit directly or inverted. The serial interface is specified for up to 16 MHz, with data set up 25 ns before and held 10 ns after the falling edge. The system clock must be fast enough that both serial clock levels last several system cycles.

Top module: `sipo_sink_driver`

## Requirements
- R1: The shift chain advances by exactly one stage on each falling edge of `ser_clk` and never on a rising edge.
- R2: A new bit enters at channel 1 (`sink_on[0]` side). After 32 falling edges, the first of those bits sits in the last stage, which feeds channel 32 (`sink_on[31]` side) and `ser_dout`. `ser_dout` always equals the last stage.
- R3: The levels of `latch_open`, `unblank` and `phase_hi` neither stall nor alter shifting.
- R4: While `latch_open` is high, the latch bank follows the shift chain, including bits shifted in while it stays high.
- R5: While `latch_open` is low, the latch bank keeps its contents, and shifting does not change `sink_on`.
- R6: With `unblank`=0 and `phase_hi`=0, every bit of `sink_on` is 1, whatever the latches hold.
- R7: With `unblank`=0 and `phase_hi`=1, every bit of `sink_on` is 0, whatever the latches hold.
- R8: With `unblank`=1 and `phase_hi`=0, each `sink_on` bit is the inverse of its latch bit.
- R9: With `unblank`=1 and `phase_hi`=1, each `sink_on` bit equals its latch bit.
- R10: A synchronous active-high `rst` clears the shift chain and the latch bank to zero. After reset, `ser_dout` is 0 and `sink_on` follows R6 to R9 applied to all-zero latches.
- R11: The captured data bit is the `ser_din` value present at the pin together with the falling edge of `ser_clk`. A change of `ser_din` one system cycle after that edge does not affect the captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock pin; shifting happens on its falling edge |
| ser_din | input | 1 | Serial data pin |
| latch_open | input | 1 | High: latch bank follows the shift chain; low: it holds |
| unblank | input | 1 | Low: all channels forced by `phase_hi`; high: channels show latch data |
| phase_hi | input | 1 | Polarity select for the forced state and for the data mapping |
| ser_dout | output | 1 | Last shift stage, for chaining |
| sink_on | output | 32 | Per-channel sink control; bit 0 is channel 1 |

## Verification
Every pin goes through two synchronizer flops. A falling `ser_clk` is therefore seen as an edge on the second system clock edge and shifted on the third, so `ser_dout` is valid three edges after the pin falls. The latch bank copies the chain one edge later, which makes the falling-edge-to-`sink_on` delay four edges. A change of `unblank` or `phase_hi` reaches `sink_on` two edges after the pin moves. The bench drives pins on the falling system clock edge and waits six system cycles before it samples. That wait covers the longest path with margin, and it stays short enough for the one-cycle hold case of R11 to be placed exactly.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  // Output stage mode picked by the unblank and phase levels
  typedef enum logic [1:0] {
    MODE_ALL_ON  = 2'b00,
    MODE_ALL_OFF = 2'b01,
    MODE_INVERT  = 2'b10,
    MODE_DIRECT  = 2'b11
  } drive_mode_e;

  // Pin bundle positions inside the synchronizer vector
  localparam int unsigned PIN_SCLK  = 0;
  localparam int unsigned PIN_SDIN  = 1;
  localparam int unsigned PIN_OPEN  = 2;
  localparam int unsigned PIN_SHOW  = 3;
  localparam int unsigned PIN_PHASE = 4;
  localparam int unsigned PIN_COUNT = 5;

  function automatic drive_mode_e mode_of(input logic show, input logic phase);
    return drive_mode_e'({show, phase});
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int unsigned DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             sdin_s,
  output logic             fall_evt,
  output logic [DEPTH-1:0] chain_q,
  output logic             tail_o
);

  logic sclk_d;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  // falling edge of the synchronized serial clock
  assign fall_evt = sclk_d & ~sclk_s;

  always_ff @(posedge clk) begin
    if (rst)           chain_q <= '0;
    else if (fall_evt) chain_q <= {chain_q[DEPTH-2:0], sdin_s};
  end

  assign tail_o = chain_q[DEPTH-1];

  AST_NO_SHIFT_WITHOUT_FALL: assert property (@(posedge clk) disable iff (rst)
    !fall_evt |=> $stable(chain_q)); // R1

  AST_TAIL_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> tail_o == $past(chain_q[DEPTH-2])); // R2

  AST_HEAD_TAKES_DATA: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> chain_q[0] == $past(sdin_s)); // R11

endmodule

// File: rtl/latch_bank.sv
module latch_bank #(
  parameter int unsigned DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_s,
  input  logic [DEPTH-1:0] chain_i,
  output logic [DEPTH-1:0] hold_q
);

  always_ff @(posedge clk) begin
    if (rst)         hold_q <= '0;
    else if (open_s) hold_q <= chain_i;
  end

  AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    open_s |=> hold_q == $past(chain_i)); // R4

  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !open_s |=> $stable(hold_q)); // R5

endmodule

// File: rtl/drive_stage.sv
module drive_stage
  import sipo_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             show_s,
  input  logic             phase_s,
  input  logic [DEPTH-1:0] hold_i,
  output logic [DEPTH-1:0] sink_o
);

  function automatic logic [DEPTH-1:0] sink_pattern(
    input drive_mode_e       mode,
    input logic [DEPTH-1:0]  bits
  );
    case (mode)
      MODE_ALL_ON:  return {DEPTH{1'b1}};
      MODE_ALL_OFF: return '0;
      MODE_INVERT:  return ~bits;
      default:      return bits;
    endcase
  endfunction

  drive_mode_e mode;

  assign mode   = mode_of(show_s, phase_s);
  assign sink_o = sink_pattern(mode, hold_i);

  AST_FORCED_ON: assert property (@(posedge clk) disable iff (rst)
    (!show_s && !phase_s) |-> (&sink_o)); // R6

  AST_FORCED_OFF: assert property (@(posedge clk) disable iff (rst)
    (!show_s && phase_s) |-> (sink_o == '0)); // R7

  AST_INVERTED: assert property (@(posedge clk) disable iff (rst)
    (show_s && !phase_s) |-> ((sink_o & hold_i) == '0 && (sink_o | hold_i) == {DEPTH{1'b1}})); // R8

  AST_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (show_s && phase_s) |-> ((sink_o ^ hold_i) == '0)); // R9

endmodule

// File: rtl/sipo_sink_driver.sv
module sipo_sink_driver
  import sipo_pkg::*;
#(
  parameter int unsigned CHANNELS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_clk,
  input  logic                ser_din,
  input  logic                latch_open,
  input  logic                unblank,
  input  logic                phase_hi,
  output logic                ser_dout,
  output logic [CHANNELS-1:0] sink_on
);

  logic [PIN_COUNT-1:0] pins_raw;
  logic [PIN_COUNT-1:0] pins_s;
  logic                 shift_fall;
  logic [CHANNELS-1:0]  chain_bits;
  logic [CHANNELS-1:0]  held_bits;

  always_comb begin
    pins_raw            = '0;
    pins_raw[PIN_SCLK]  = ser_clk;
    pins_raw[PIN_SDIN]  = ser_din;
    pins_raw[PIN_OPEN]  = latch_open;
    pins_raw[PIN_SHOW]  = unblank;
    pins_raw[PIN_PHASE] = phase_hi;
  end

  pin_sync #(
    .WIDTH  (PIN_COUNT),
    .STAGES (SYNC_STAGES)
  ) i_pin_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pins_raw),
    .sync_o (pins_s)
  );

  shift_chain #(
    .DEPTH (CHANNELS)
  ) i_shift_chain (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s[PIN_SCLK]),
    .sdin_s   (pins_s[PIN_SDIN]),
    .fall_evt (shift_fall),
    .chain_q  (chain_bits),
    .tail_o   (ser_dout)
  );

  latch_bank #(
    .DEPTH (CHANNELS)
  ) i_latch_bank (
    .clk     (clk),
    .rst     (rst),
    .open_s  (pins_s[PIN_OPEN]),
    .chain_i (chain_bits),
    .hold_q  (held_bits)
  );

  drive_stage #(
    .DEPTH (CHANNELS)
  ) i_drive_stage (
    .clk     (clk),
    .rst     (rst),
    .show_s  (pins_s[PIN_SHOW]),
    .phase_s (pins_s[PIN_PHASE]),
    .hold_i  (held_bits),
    .sink_o  (sink_on)
  );

  AST_TAIL_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !shift_fall |=> $stable(ser_dout)); // R3

endmodule

// File: tb/test_sipo_sink_driver.sv
module test_sipo_sink_driver;

  localparam int unsigned CH      = 32;
  localparam int unsigned SETTLE  = 6;
  localparam int unsigned LIMIT   = 150000;
  localparam int unsigned NVEC    = 6;

  // {word, unblank, phase_hi}
  localparam logic [CH+1:0] VEC [NVEC] = '{
    {32'hA5C3_0F01, 1'b1, 1'b1},
    {32'h8000_0001, 1'b1, 1'b0},
    {32'hFFFF_FFFF, 1'b0, 1'b0},
    {32'h0000_0000, 1'b0, 1'b1},
    {32'h1234_5678, 1'b1, 1'b1},
    {32'hDEAD_BEEF, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          ser_clk;
  logic          ser_din;
  logic          latch_open;
  logic          unblank;
  logic          phase_hi;
  logic          ser_dout;
  logic [CH-1:0] sink_on;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  int unsigned cycles   = 0;
  bit          done     = 1'b0;

  always #4 clk = ~clk;

  sipo_sink_driver i_sipo_sink_driver (
    .clk        (clk),
    .rst        (rst),
    .ser_clk    (ser_clk),
    .ser_din    (ser_din),
    .latch_open (latch_open),
    .unblank    (unblank),
    .phase_hi   (phase_hi),
    .ser_dout   (ser_dout),
    .sink_on    (sink_on)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > LIMIT && !done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  // expected channel pattern, written per mode from the requirements
  function automatic logic [CH-1:0] model_out(input logic [CH-1:0] held,
                                              input logic show, input logic ph);
    logic [CH-1:0] r;
    if (!show) r = ph ? {CH{1'b0}} : {CH{1'b1}};      // R6, R7
    else begin
      for (int i = 0; i < CH; i++) r[i] = ph ? held[i] : !held[i]; // R8, R9
    end
    return r;
  endfunction

  task automatic wait_cyc(input int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_din = b;
    ser_clk = 1'b1;
    wait_cyc(SETTLE);
    ser_clk = 1'b0;
    wait_cyc(SETTLE);
  endtask

  task automatic shift_word(input logic [CH-1:0] w);
    for (int i = CH - 1; i >= 0; i--) shift_bit(w[i]);
    ser_clk = 1'b1;
    wait_cyc(SETTLE);
  endtask

  logic [CH-1:0] ref_chain;
  logic [CH-1:0] ref_held;

  initial begin
    rst = 1'b1; ser_clk = 1'b1; ser_din = 1'b0;
    latch_open = 1'b0; unblank = 1'b1; phase_hi = 1'b1;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(SETTLE);

    // reset state
    check("R10 direct after reset", sink_on, '0);
    check("R10 dout after reset", {31'b0, ser_dout}, '0);
    phase_hi = 1'b0;
    wait_cyc(SETTLE);
    check("R10 invert after reset", sink_on, {CH{1'b1}});

    // table of vectors
    for (int v = 0; v < NVEC; v++) begin
      logic [CH-1:0] w;
      w = VEC[v][CH+1:2];
      latch_open = 1'b0;
      shift_word(w);
      latch_open = 1'b1;
      wait_cyc(SETTLE);
      latch_open = 1'b0;
      unblank  = VEC[v][1];
      phase_hi = VEC[v][0];
      wait_cyc(SETTLE);
      check("R2/R6-R9 vector outputs", sink_on, model_out(w, VEC[v][1], VEC[v][0]));
      check("R2 dout last stage", {31'b0, ser_dout}, {31'b0, w[CH-1]});
    end

    // R3: control levels toggle during shifting, latches open
    ref_chain  = 32'hC0DE_5AA5;
    latch_open = 1'b1;
    for (int i = CH - 1; i >= 0; i--) begin
      unblank  = i[0];
      phase_hi = i[1];
      shift_bit(ref_chain[i]);
    end
    ser_clk  = 1'b1;
    unblank  = 1'b1;
    phase_hi = 1'b1;
    wait_cyc(SETTLE);
    check("R3 shift unaffected by controls", sink_on, ref_chain);
    check("R3 dout unaffected", {31'b0, ser_dout}, {31'b0, ref_chain[CH-1]});

    // R1: fall shifts, rise does not
    ser_din = 1'b0;
    ser_clk = 1'b0;
    wait_cyc(SETTLE);
    ref_chain = {ref_chain[CH-2:0], 1'b0};
    check("R1 falling edge shifts", sink_on, ref_chain);
    ser_din = 1'b1;
    ser_clk = 1'b1;
    wait_cyc(SETTLE);
    check("R1 rising edge ignored", sink_on, ref_chain);

    // R4: transparent latch follows a fresh bit
    shift_bit(1'b1);
    ref_chain = {ref_chain[CH-2:0], 1'b1};
    check("R4 transparent follow", sink_on, ref_chain);
    ser_clk = 1'b1;
    wait_cyc(SETTLE);

    // R5: closed latch holds while a new word is shifted
    ref_held   = ref_chain;
    latch_open = 1'b0;
    wait_cyc(SETTLE);
    ref_chain = 32'h0F0F_3C3C;
    shift_word(ref_chain);
    check("R5 hold while closed", sink_on, ref_held);
    check("R5 dout still shifts", {31'b0, ser_dout}, {31'b0, ref_chain[CH-1]});
    latch_open = 1'b1;
    wait_cyc(SETTLE);
    check("R4 reopen loads chain", sink_on, ref_chain);

    // R11: data changing together with the edge, then one cycle after it
    ser_din = 1'b0;
    wait_cyc(SETTLE);
    ser_din = 1'b1;
    ser_clk = 1'b0;
    wait_cyc(SETTLE);
    ref_chain = {ref_chain[CH-2:0], 1'b1};
    check("R11 data taken with edge", sink_on, ref_chain);
    ser_clk = 1'b1;
    wait_cyc(SETTLE);
    ser_din = 1'b0;
    ser_clk = 1'b0;
    wait_cyc(1);
    ser_din = 1'b1;
    wait_cyc(SETTLE);
    ref_chain = {ref_chain[CH-2:0], 1'b0};
    check("R11 late data change ignored", sink_on, ref_chain);
    ser_clk = 1'b1;
    wait_cyc(SETTLE);

    // R10: reset in mid-run clears nonzero state
    rst = 1'b1;
    wait_cyc(2);
    rst = 1'b0;
    wait_cyc(SETTLE);
    check("R10 mid-run reset clears", sink_on, '0);
    check("R10 mid-run reset dout", {31'b0, ser_dout}, '0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule